// File: doc/BRIEF.md
# Instruction Field Decoder

This block splits a 32-bit instruction word into the pieces that the execute stages need. It produces the source and destination register indices, a fully extended 32-bit immediate, a one-hot operation class, and a set of flags. The flags mark illegal encodings, the nop and halt aliases, the two software traps, and right shifts whose amount has to be checked at run time. The most significant opcode bit picks the operand format. Each opcode picks how its immediate is extended or placed.

Four static enable inputs say whether the multiplier, divider, barrel shifter and sign extender exist. An operation whose unit is absent decodes as illegal. The one exception is a right shift by exactly one, which stays legal without the shifter. Instructions arrive on a valid/ready handshake at one per cycle. By default the decode result is held in an output register that stalls when downstream is not ready.

Top module: `instr_field_decoder`

## Requirements
- R1: The opcode is bits 31:26. Bit 31 set selects register-register format (out_rr_fmt=1, out_rd = bits 15:11); bit 31 clear selects register-immediate format (out_rd = bits 20:16). out_ra is always bits 25:21 and out_rb is always bits 20:16.
- R2: The 16-bit immediate (bits 15:0) is sign-extended for these opcodes: 13 (add), 2 (multiply), 25, 26, 27 and 31 (signed compares), 4, 7, 10, 11 and 16 (loads), and 3, 12 and 22 (stores). For the conditional branch opcodes 17 to 21 and 23 it is sign-extended and then multiplied by 4.
- R3: The 16-bit immediate is zero-extended for opcodes 1, 6, 8, 9 and 14 (NOR, XOR, AND, XNOR, OR) and for opcodes 28 and 29 (unsigned compares).
- R4: Opcodes 24 and 30 (high-half AND/OR) place the 16-bit immediate in bits 31:16, with zeros in bits 15:0.
- R5: Opcodes 0, 5, 15 and 43 give the 5-bit field (bits 4:0), zero-extended. Opcodes 56 and 62 give bits 25:0, sign-extended and multiplied by 4. Every other opcode gives an immediate of 0.
- R6: out_class is one-hot, with bit 0 arithmetic {13,45,50}, bit 1 logic {1,6,8,9,14,24,30,33,38,40,41,46}, bit 2 shift {0,5,15,32,37,47}, bit 3 multiply/divide {2,34,35,49}, bit 4 sign-extend {44,55}, bit 5 load {4,7,10,11,16}, bit 6 store {3,12,22}, bit 7 branch {17..21,23}, bit 8 jump {48,54,56,62}, bit 9 compare {25..29,31,57..61,63}, bit 10 control register {36,52}, bit 11 system {43}.
- R7: Opcodes 39, 42, 51 (user-defined) and 53 decode with out_illegal=1. Any illegal decode has out_class=0.
- R8: Opcodes 2 and 34 are illegal when en_mul=0. Opcodes 35 and 49 are illegal when en_div=0. Opcodes 44 and 55 are illegal when en_sext=0. Opcodes 15 and 47 (left shift) are illegal when en_shift=0.
- R9: When en_shift=0, the immediate right shifts (opcodes 0 and 5) are legal only when bits 4:0 equal 1. The register right shifts (32 and 37) stay legal, with out_shamt_chk=1. out_shamt_chk is 0 in every other case.
- R10: For opcode 43, a value of 2 in bits 4:0 sets out_trap_brk and a value of 7 sets out_trap_sys. Any other value is illegal.
- R11: Opcode 13 with bits 25:16 zero and bits 15:0 zero sets out_nop. Opcode 40 with bits 25:11 zero sets out_halt and gives out_class bit 11 only.
- R12: in_ready = !out_valid || out_ready. An accepted word shows its decode one clock later. While out_valid=1 and out_ready=0, all outputs hold.
- R13: Synchronous active-high reset clears out_valid and drives the nop decode: out_nop=1, out_class=1, and all other fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| en_mul | input | 1 | multiplier present |
| en_div | input | 1 | divider present |
| en_shift | input | 1 | barrel shifter present |
| en_sext | input | 1 | sign extender present |
| in_valid | input | 1 | instruction word valid |
| in_ready | output | 1 | decoder accepts a word |
| in_instr | input | 32 | instruction word |
| out_ready | input | 1 | downstream accepts the result |
| out_valid | output | 1 | result valid |
| out_class | output | 12 | one-hot operation class |
| out_illegal | output | 1 | illegal encoding |
| out_nop | output | 1 | nop alias |
| out_halt | output | 1 | halt alias |
| out_trap_brk | output | 1 | breakpoint trap |
| out_trap_sys | output | 1 | system-call trap |
| out_rr_fmt | output | 1 | register-register format |
| out_shamt_chk | output | 1 | execute must require shift amount 1 |
| out_ra | output | 5 | register field A |
| out_rb | output | 5 | register field B |
| out_rd | output | 5 | destination register |
| out_imm | output | 32 | extended immediate |

## Verification
The decoder is stateless apart from the output register, so a wrong entry in an opcode table shows up as a wrong class, immediate or illegal flag on exactly the cycle after that opcode is accepted. Nothing is hidden behind later state. The bench therefore sweeps all 64 opcodes against all 16 enable combinations, using field patterns that hit the alias, trap and shift-amount corners. A fault in the output register's stall path appears as a changed result while out_ready is low, on the first held cycle.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int IW   = 32;
  localparam int OPW  = 6;
  localparam int RW   = 5;
  localparam int NCLS = 12;

  localparam int C_ARITH = 0;
  localparam int C_LOGIC = 1;
  localparam int C_SHIFT = 2;
  localparam int C_MULDV = 3;
  localparam int C_SEXT  = 4;
  localparam int C_LOAD  = 5;
  localparam int C_STORE = 6;
  localparam int C_BRAN  = 7;
  localparam int C_JUMP  = 8;
  localparam int C_CMP   = 9;
  localparam int C_CSR   = 10;
  localparam int C_SYS   = 11;

  typedef struct packed {
    logic [NCLS-1:0] cls;
    logic            illegal;
    logic            nop;
    logic            halt;
    logic            trap_brk;
    logic            trap_sys;
    logic            rr_fmt;
    logic            shamt_chk;
    logic [RW-1:0]   ra;
    logic [RW-1:0]   rb;
    logic [RW-1:0]   rd;
    logic [IW-1:0]   imm;
  } dec_t;

  localparam int DW = $bits(dec_t);

  localparam dec_t DEC_NOP = '{cls: NCLS'(1), illegal: 1'b0, nop: 1'b1, halt: 1'b0,
                               trap_brk: 1'b0, trap_sys: 1'b0, rr_fmt: 1'b0,
                               shamt_chk: 1'b0, ra: '0, rb: '0, rd: '0, imm: '0};

  function automatic logic [IW-1:0] sx16(input logic [15:0] v);
    return {{(IW-16){v[15]}}, v};
  endfunction

  function automatic logic [IW-1:0] zx16(input logic [15:0] v);
    return {{(IW-16){1'b0}}, v};
  endfunction

  function automatic logic [IW-1:0] sx26x4(input logic [25:0] v);
    return {{(IW-28){v[25]}}, v, 2'b00};
  endfunction
endpackage

// File: rtl/ifd_imm_gen.sv
module ifd_imm_gen import ifd_pkg::*; (
  input  logic [OPW-1:0] op,
  input  logic [25:0]    field,
  output logic [IW-1:0]  imm
);
  logic [15:0] f16;
  assign f16 = field[15:0];

  always_comb begin
    case (op)
      6'd13, 6'd2, 6'd25, 6'd26, 6'd27, 6'd31,
      6'd4, 6'd7, 6'd10, 6'd11, 6'd16,
      6'd3, 6'd12, 6'd22:                     imm = sx16(f16);
      6'd1, 6'd6, 6'd8, 6'd9, 6'd14,
      6'd28, 6'd29:                           imm = zx16(f16);
      6'd24, 6'd30:                           imm = {f16, 16'h0000};
      6'd0, 6'd5, 6'd15, 6'd43:               imm = {{(IW-5){1'b0}}, f16[4:0]};
      6'd17, 6'd18, 6'd19, 6'd20, 6'd21,
      6'd23:                                  imm = sx16(f16) << 2;
      6'd56, 6'd62:                           imm = sx26x4(field);
      default:                                imm = '0;
    endcase
  end
endmodule

// File: rtl/ifd_classify.sv
module ifd_classify import ifd_pkg::*; (
  input  logic [OPW-1:0]  op,
  input  logic [RW-1:0]   fa,
  input  logic [RW-1:0]   fb,
  input  logic [15:0]     f16,
  input  logic            en_mul,
  input  logic            en_div,
  input  logic            en_shift,
  input  logic            en_sext,
  output logic [NCLS-1:0] cls,
  output logic            illegal,
  output logic            nop,
  output logic            halt,
  output logic            trap_brk,
  output logic            trap_sys,
  output logic            shamt_chk
);
  logic [NCLS-1:0] base;
  logic [4:0]      sh5;
  logic [RW-1:0]   fc;
  logic need_mul, need_div, need_sext, shl_op, shr_imm, shr_reg, sys_op, bad;

  assign sh5 = f16[4:0];
  assign fc  = f16[15:11];

  always_comb begin
    base = '0;
    case (op)
      6'd13, 6'd45, 6'd50:                                base[C_ARITH] = 1'b1;
      6'd1, 6'd6, 6'd8, 6'd9, 6'd14, 6'd24, 6'd30,
      6'd33, 6'd38, 6'd40, 6'd41, 6'd46:                  base[C_LOGIC] = 1'b1;
      6'd0, 6'd5, 6'd15, 6'd32, 6'd37, 6'd47:             base[C_SHIFT] = 1'b1;
      6'd2, 6'd34, 6'd35, 6'd49:                          base[C_MULDV] = 1'b1;
      6'd44, 6'd55:                                       base[C_SEXT]  = 1'b1;
      6'd4, 6'd7, 6'd10, 6'd11, 6'd16:                    base[C_LOAD]  = 1'b1;
      6'd3, 6'd12, 6'd22:                                 base[C_STORE] = 1'b1;
      6'd17, 6'd18, 6'd19, 6'd20, 6'd21, 6'd23:           base[C_BRAN]  = 1'b1;
      6'd48, 6'd54, 6'd56, 6'd62:                         base[C_JUMP]  = 1'b1;
      6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd31,
      6'd57, 6'd58, 6'd59, 6'd60, 6'd61, 6'd63:           base[C_CMP]   = 1'b1;
      6'd36, 6'd52:                                       base[C_CSR]   = 1'b1;
      6'd43:                                              base[C_SYS]   = 1'b1;
      default:                                            base = '0;
    endcase
  end

  assign need_mul  = (op == 6'd2)  || (op == 6'd34);
  assign need_div  = (op == 6'd35) || (op == 6'd49);
  assign need_sext = (op == 6'd44) || (op == 6'd55);
  assign shl_op    = (op == 6'd15) || (op == 6'd47);
  assign shr_imm   = (op == 6'd0)  || (op == 6'd5);
  assign shr_reg   = (op == 6'd32) || (op == 6'd37);
  assign sys_op    = (op == 6'd43);

  assign trap_brk  = sys_op && (sh5 == 5'd2);
  assign trap_sys  = sys_op && (sh5 == 5'd7);
  assign halt      = (op == 6'd40) && (fa == '0) && (fb == '0) && (fc == '0);
  assign nop       = (op == 6'd13) && (fa == '0) && (fb == '0) && (f16 == '0);
  assign shamt_chk = shr_reg && !en_shift;

  assign bad = (base == '0)
             | (need_mul  & ~en_mul)
             | (need_div  & ~en_div)
             | (need_sext & ~en_sext)
             | (shl_op    & ~en_shift)
             | (shr_imm   & ~en_shift & (sh5 != 5'd1))
             | (sys_op    & ~trap_brk & ~trap_sys);

  assign illegal = bad;
  assign cls     = bad  ? '0
                 : halt ? NCLS'(1) << C_SYS
                 : base;
endmodule

// File: rtl/ifd_out_stage.sv
module ifd_out_stage #(
  parameter int          W       = 8,
  parameter bit          REG_OUT = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;
      assign in_ready = !v_q || out_ready;
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= RST_VAL;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end
      assign out_valid = v_q;
      assign out_data  = d_q;

      // R12
      stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder import ifd_pkg::*; #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_mul,
  input  logic            en_div,
  input  logic            en_shift,
  input  logic            en_sext,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IW-1:0]   in_instr,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [NCLS-1:0] out_class,
  output logic            out_illegal,
  output logic            out_nop,
  output logic            out_halt,
  output logic            out_trap_brk,
  output logic            out_trap_sys,
  output logic            out_rr_fmt,
  output logic            out_shamt_chk,
  output logic [RW-1:0]   out_ra,
  output logic [RW-1:0]   out_rb,
  output logic [RW-1:0]   out_rd,
  output logic [IW-1:0]   out_imm
);
  localparam logic [DW-1:0] NOP_WORD = DEC_NOP;

  logic [OPW-1:0] op;
  dec_t           d_c;
  dec_t           d_q;
  logic [DW-1:0]  d_q_bits;

  assign op        = in_instr[IW-1 -: OPW];
  assign d_c.rr_fmt = in_instr[IW-1];
  assign d_c.ra    = in_instr[25:21];
  assign d_c.rb    = in_instr[20:16];
  assign d_c.rd    = in_instr[IW-1] ? in_instr[15:11] : in_instr[20:16];

  ifd_imm_gen u_imm (
    .op    (op),
    .field (in_instr[25:0]),
    .imm   (d_c.imm)
  );

  ifd_classify u_cls (
    .op        (op),
    .fa        (in_instr[25:21]),
    .fb        (in_instr[20:16]),
    .f16       (in_instr[15:0]),
    .en_mul    (en_mul),
    .en_div    (en_div),
    .en_shift  (en_shift),
    .en_sext   (en_sext),
    .cls       (d_c.cls),
    .illegal   (d_c.illegal),
    .nop       (d_c.nop),
    .halt      (d_c.halt),
    .trap_brk  (d_c.trap_brk),
    .trap_sys  (d_c.trap_sys),
    .shamt_chk (d_c.shamt_chk)
  );

  ifd_out_stage #(.W(DW), .REG_OUT(REG_OUT), .RST_VAL(NOP_WORD)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (d_c),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (d_q_bits)
  );

  assign d_q           = dec_t'(d_q_bits);
  assign out_class     = d_q.cls;
  assign out_illegal   = d_q.illegal;
  assign out_nop       = d_q.nop;
  assign out_halt      = d_q.halt;
  assign out_trap_brk  = d_q.trap_brk;
  assign out_trap_sys  = d_q.trap_sys;
  assign out_rr_fmt    = d_q.rr_fmt;
  assign out_shamt_chk = d_q.shamt_chk;
  assign out_ra        = d_q.ra;
  assign out_rb        = d_q.rb;
  assign out_rd        = d_q.rd;
  assign out_imm       = d_q.imm;

  // R7
  illegal_no_class_chk: assert property (@(posedge clk) disable iff (rst)
    d_c.illegal |-> (d_c.cls == '0));
  // R6
  legal_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    !d_c.illegal |-> $onehot(d_c.cls));
  // R11
  nop_alias_chk: assert property (@(posedge clk) disable iff (rst)
    d_c.nop |-> (!d_c.illegal && d_c.imm == '0 && d_c.cls[C_ARITH]));
  // R11
  halt_alias_chk: assert property (@(posedge clk) disable iff (rst)
    d_c.halt |-> (d_c.cls == (NCLS'(1) << C_SYS)));
  // R9
  shamt_rr_only_chk: assert property (@(posedge clk) disable iff (rst)
    d_c.shamt_chk |-> (d_c.rr_fmt && !d_c.illegal && !en_shift));
endmodule

// File: tb/sim_instr_field_decoder.sv
module sim_instr_field_decoder;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_mul = 1'b1, en_div = 1'b1, en_shift = 1'b1, en_sext = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_instr = '0;
  logic in_ready, out_valid;
  logic [11:0] out_class;
  logic out_illegal, out_nop, out_halt, out_trap_brk, out_trap_sys, out_rr_fmt, out_shamt_chk;
  logic [4:0] out_ra, out_rb, out_rd;
  logic [31:0] out_imm;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  instr_field_decoder u0 (
    .clk(clk), .rst(rst), .en_mul(en_mul), .en_div(en_div), .en_shift(en_shift),
    .en_sext(en_sext), .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .out_ready(out_ready), .out_valid(out_valid), .out_class(out_class),
    .out_illegal(out_illegal), .out_nop(out_nop), .out_halt(out_halt),
    .out_trap_brk(out_trap_brk), .out_trap_sys(out_trap_sys), .out_rr_fmt(out_rr_fmt),
    .out_shamt_chk(out_shamt_chk), .out_ra(out_ra), .out_rb(out_rb), .out_rd(out_rd),
    .out_imm(out_imm)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int cls_idx(input int op);
    if (op inside {13, 45, 50}) return 0;
    if (op inside {1, 6, 8, 9, 14, 24, 30, 33, 38, 40, 41, 46}) return 1;
    if (op inside {0, 5, 15, 32, 37, 47}) return 2;
    if (op inside {2, 34, 35, 49}) return 3;
    if (op inside {44, 55}) return 4;
    if (op inside {4, 7, 10, 11, 16}) return 5;
    if (op inside {3, 12, 22}) return 6;
    if (op inside {[17:21], 23}) return 7;
    if (op inside {48, 54, 56, 62}) return 8;
    if (op inside {[25:29], 31, [57:61], 63}) return 9;
    if (op inside {36, 52}) return 10;
    if (op == 43) return 11;
    return -1;
  endfunction

  function automatic string imm_req(input int op);
    if (op inside {13, 2, 25, 26, 27, 31, 4, 7, 10, 11, 16, 3, 12, 22, [17:21], 23}) return "R2";
    if (op inside {1, 6, 8, 9, 14, 28, 29}) return "R3";
    if (op inside {24, 30}) return "R4";
    return "R5";
  endfunction

  function automatic logic [31:0] exp_imm(input int op, input logic [31:0] w);
    int s16;
    int s26;
    s16 = int'(w[15:0]);
    if (s16 >= 32768) s16 = s16 - 65536;
    s26 = int'(w[25:0]);
    if (s26 >= 33554432) s26 = s26 - 67108864;
    if (op inside {13, 2, 25, 26, 27, 31, 4, 7, 10, 11, 16, 3, 12, 22}) return 32'(s16);
    if (op inside {[17:21], 23}) return 32'(s16 * 4);
    if (op inside {1, 6, 8, 9, 14, 28, 29}) return 32'(w % 65536);
    if (op inside {24, 30}) return (w % 65536) * 65536;
    if (op inside {0, 5, 15, 43}) return w % 32;
    if (op inside {56, 62}) return 32'(s26 * 4);
    return 32'd0;
  endfunction

  function automatic bit exp_bad(input int op, input logic [31:0] w, input logic [3:0] f);
    int sa;
    sa = int'(w % 32);
    if (cls_idx(op) < 0) return 1'b1;
    if (op inside {2, 34} && !f[0]) return 1'b1;
    if (op inside {35, 49} && !f[1]) return 1'b1;
    if (op inside {15, 47} && !f[2]) return 1'b1;
    if (op inside {0, 5} && !f[2] && sa != 1) return 1'b1;
    if (op inside {44, 55} && !f[3]) return 1'b1;
    if (op == 43 && sa != 2 && sa != 7) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_out(input logic [31:0] w, input logic [3:0] f);
    int op;
    bit bad, hlt, nopx;
    logic [11:0] ecls;
    op   = int'(w / 32'h0400_0000);
    bad  = exp_bad(op, w, f);
    hlt  = (op == 40) && ((w / 2048) % 32768 == 0);
    nopx = (op == 13) && (w % 67108864 == 0);
    if (bad) ecls = '0;
    else if (hlt) ecls = 12'h800;
    else ecls = 12'(1) << cls_idx(op);
    chk("R12", "valid", 64'(out_valid), 64'd1);
    chk("R1", "fmt", 64'(out_rr_fmt), 64'(op >= 32));
    chk("R1", "ra", 64'(out_ra), 64'((w / 2097152) % 32));
    chk("R1", "rb", 64'(out_rb), 64'((w / 65536) % 32));
    chk("R1", "rd", 64'(out_rd), op >= 32 ? 64'((w / 2048) % 32) : 64'((w / 65536) % 32));
    chk(imm_req(op), "imm", 64'(out_imm), 64'(exp_imm(op, w)));
    chk(bad ? "R7" : "R6", "class", 64'(out_class), 64'(ecls));
    chk(op inside {2, 34, 35, 49, 44, 55, 15, 47} ? "R8" : (op inside {0, 5} ? "R9" : "R7"),
        "illegal", 64'(out_illegal), 64'(bad));
    chk("R9", "shamt_chk", 64'(out_shamt_chk), 64'(op inside {32, 37} && !f[2]));
    chk("R10", "brk", 64'(out_trap_brk), 64'(op == 43 && w % 32 == 2));
    chk("R10", "sys", 64'(out_trap_sys), 64'(op == 43 && w % 32 == 7));
    chk("R11", "nop", 64'(out_nop), 64'(nopx));
    chk("R11", "halt", 64'(out_halt), 64'(hlt));
  endtask

  function automatic logic [25:0] pattern(input int p, input int op);
    case (p)
      0: return 26'h0;
      1: return 26'h3FF_FFFF;
      2: return {5'd3, 5'd17, 16'h4802};
      3: return {5'd0, 5'd0, 16'h8007};
      4: return {5'd31, 5'd0, 16'h7FE1};
      default: return 26'((op + 1) * 32'h9E37_79B1);
    endcase
  endfunction

  initial begin
    #(PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] wa, wb;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "valid", 64'(out_valid), 64'd0);
    chk("R13", "nop", 64'(out_nop), 64'd1);
    chk("R13", "class", 64'(out_class), 64'd1);
    chk("R13", "imm", 64'(out_imm), 64'd0);
    chk("R13", "illegal", 64'(out_illegal), 64'd0);
    chk("R12", "ready", 64'(in_ready), 64'd1);
    rst = 1'b0;
    @(negedge clk);

    for (int f = 0; f < 16; f++) begin
      en_mul = f[0]; en_div = f[1]; en_shift = f[2]; en_sext = f[3];
      for (int op = 0; op < 64; op++) begin
        for (int p = 0; p < 6; p++) begin
          in_instr = {6'(op), pattern(p, op)};
          in_valid = 1'b1;
          @(negedge clk);
          check_out(in_instr, 4'(f));
        end
      end
    end

    // R12 stall behaviour
    en_mul = 1'b1; en_div = 1'b1; en_shift = 1'b1; en_sext = 1'b1;
    wa = {6'd13, 5'd1, 5'd2, 16'hFFFE};
    wb = {6'd8, 5'd4, 5'd5, 16'h8001};
    in_instr = wa; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    chk("R12", "first imm", 64'(out_imm), 64'(32'hFFFF_FFFE));
    out_ready = 1'b0; in_instr = wb;
    #1;
    chk("R12", "ready low", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk("R12", "held imm", 64'(out_imm), 64'(32'hFFFF_FFFE));
    chk("R12", "held rb", 64'(out_rb), 64'd2);
    chk("R12", "held valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R12", "next imm", 64'(out_imm), 64'(32'h0000_8001));
    chk("R12", "next class", 64'(out_class), 64'h2);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R12", "drained", 64'(out_valid), 64'd0);

    // R13 reset again after traffic
    rst = 1'b1;
    @(negedge clk);
    chk("R13", "valid", 64'(out_valid), 64'd0);
    chk("R13", "rd", 64'(out_rd), 64'd0);
    chk("R13", "nop", 64'(out_nop), 64'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule